// File: doc/BRIEF.md
# Dynamic VID Reference Stepper

This block follows the voltage-identification code that a processor drives while the regulator runs. It moves an internal reference code for the DAC toward that code one LSB at a time, and each LSB is 12.5 mV. The VID bus is asynchronous to the block, so it first passes through a two-flop synchronizer.

A runtime cycle-length input gives the switching period in clocks. The block divides that period into six equal slots and samples the synchronized code at the end of each slot. When a sample differs from the reference, the block waits a qualification period of three slots, which is half a switching period. It steps only if the target-minus-reference difference stays the same for the whole wait. If the difference changes at any sample during the wait, the wait is dropped with no step.

A code that is several LSBs away is still reached, one qualified step at a time. Consecutive steps are half a period apart. While enable is low or reset is high, the reference copies the synchronized code directly and no stepping takes place.

Top module: `vid_ref_stepper`

## Requirements
- R1: While `rst` is high or `en` is low, at every clock `dac_code` loads the synchronized VID code directly, and `busy` reads 0. Raising `en` does not change `dac_code` by itself.
- R2: While enabled, the synchronized code is sampled once every `cyc_len/6` clocks, which gives six evenly spaced samples per switching cycle.
- R3: A sample that differs from `dac_code` starts a wait of three sample slots (`cyc_len/2` clocks). The first step therefore appears no sooner than `cyc_len/2` clocks after the new code is seen.
- R4: Every change of `dac_code` while enabled is exactly +1 or -1, in the direction of the sampled target.
- R5: If the difference (sampled code minus `dac_code`) at any sample during a wait is not the same as it was when the wait began, the wait is abandoned and `dac_code` does not change. A code that changes and returns to `dac_code` within one wait leaves `dac_code` and `busy` unchanged.
- R6: After an abandoned wait, a new wait starts at the next sample whose code still differs from `dac_code`, and that wait leads to steps as usual.
- R7: When a step leaves the target not yet reached, a new wait starts at once. Consecutive steps are exactly `cyc_len/2` clocks apart until `dac_code` equals the target.
- R8: `vid_in` passes through two flip-flops. With `en` low, a change on `vid_in` shows on `dac_code` at the third rising clock edge and not earlier.
- R9: `busy` is 1 exactly when `dac_code` differs from the most recent sampled code. It is 1 throughout every qualification wait.
- R10: `cyc_len` must be a multiple of 6 and at least 12 while `en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables stepping; when low the reference tracks the code directly |
| vid_in | input | VID_W | Asynchronous VID code from the processor |
| cyc_len | input | CYC_W | Switching-cycle length in clocks |
| dac_code | output | VID_W | Reference code for the DAC |
| busy | output | 1 | Reference differs from the last sampled code |

## Verification
The assertions assume that `cyc_len` is a legal multiple of six, no smaller than twelve, and that it holds still while `en` is high. The bench changes `cyc_len` only while `en` is low, and it uses only 12 and 30. The assertions also assume that the VID code does not wrap past either end of its range. The bench keeps every target well inside the code range. It changes the VID code either once per test or at a chosen offset, so that a change lands inside a running wait.

// File: rtl/vref_pkg.sv
package vref_pkg;

    localparam int unsigned SLOTS_PER_CYC = 6;
    localparam int unsigned WAIT_SLOTS    = SLOTS_PER_CYC / 2;
    localparam int unsigned MIN_CYC       = 12;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } vstate_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } vdir_e;

    function automatic int unsigned slot_clocks(input int unsigned cyc);
        return cyc / SLOTS_PER_CYC;
    endfunction

    function automatic vdir_e dir_of(input logic sign_bit, input logic nonzero);
        if (!nonzero)
            return DIR_HOLD;
        else if (sign_bit)
            return DIR_DN;
        else
            return DIR_UP;
    endfunction

endpackage

// File: rtl/vref_sync.sv
module vref_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/vref_slot_timer.sv
module vref_slot_timer
    import vref_pkg::*;
#(
    parameter int unsigned CYC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CYC_W-1:0] cyc_len,
    output logic             strobe
);
    logic [CYC_W-1:0] slot_cnt;
    logic [CYC_W-1:0] slot_len;

    assign slot_len = CYC_W'(slot_clocks(int'(cyc_len)));
    assign strobe   = en && (slot_cnt == slot_len - CYC_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            slot_cnt <= '0;
        end else if (strobe) begin
            slot_cnt <= '0;
        end else begin
            slot_cnt <= slot_cnt + CYC_W'(1);
        end
    end

    AST_CYC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        en |-> (int'(cyc_len) >= int'(MIN_CYC)) && ((int'(cyc_len) % int'(SLOTS_PER_CYC)) == 0)); // R10

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $stable(cyc_len)) |-> (slot_cnt < slot_len)); // R2

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && strobe) |=> (!en || slot_cnt == '0)); // R2
endmodule

// File: rtl/vref_stepper.sv
module vref_stepper
    import vref_pkg::*;
#(
    parameter int unsigned VID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             strobe,
    input  logic [VID_W-1:0] vid_s,
    output logic [VID_W-1:0] dac_code,
    output logic             busy
);
    localparam int unsigned DW = VID_W + 1;
    localparam int unsigned WC_W = $clog2(WAIT_SLOTS + 1);

    typedef logic signed [DW-1:0] diff_t;

    vstate_e          state_q;
    logic [VID_W-1:0] dac_q;
    logic [VID_W-1:0] samp_q;
    diff_t            ref_diff_q;
    logic [WC_W-1:0]  wcnt_q;

    diff_t cur_diff;
    diff_t next_diff;
    vdir_e dir;
    logic  far;

    assign cur_diff = diff_t'({1'b0, vid_s}) - diff_t'({1'b0, dac_q});
    assign dir      = dir_of(cur_diff[DW-1], cur_diff != '0);
    assign far      = (cur_diff > diff_t'(1)) || (cur_diff < -diff_t'(1));
    assign next_diff = (dir == DIR_UP) ? cur_diff - diff_t'(1) : cur_diff + diff_t'(1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dac_q      <= vid_s;
            samp_q     <= vid_s;
            state_q    <= ST_IDLE;
            ref_diff_q <= '0;
            wcnt_q     <= '0;
        end else if (strobe) begin
            samp_q <= vid_s;
            unique case (state_q)
                ST_IDLE: begin
                    if (dir != DIR_HOLD) begin
                        state_q    <= ST_WAIT;
                        ref_diff_q <= cur_diff;
                        wcnt_q     <= '0;
                    end
                end
                ST_WAIT: begin
                    if (cur_diff != ref_diff_q) begin
                        state_q <= ST_IDLE;
                        wcnt_q  <= '0;
                    end else if (wcnt_q == WC_W'(WAIT_SLOTS - 1)) begin
                        if (dir == DIR_UP)
                            dac_q <= dac_q + VID_W'(1);
                        else
                            dac_q <= dac_q - VID_W'(1);
                        wcnt_q <= '0;
                        if (far) begin
                            ref_diff_q <= next_diff;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        wcnt_q <= wcnt_q + WC_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dac_code = dac_q;
    assign busy     = (dac_q != samp_q);

    AST_ONE_LSB: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |->
            (dac_q == $past(dac_q) || dac_q == $past(dac_q) + VID_W'(1) || dac_q == $past(dac_q) - VID_W'(1))); // R4

    AST_STEP_ON_SLOT: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst) && dac_q != $past(dac_q)) |-> $past(strobe)); // R3

    AST_ABANDON_HOLD: assert property (@(posedge clk) disable iff (rst || !en)
        (state_q == ST_WAIT && strobe && cur_diff != ref_diff_q) |=> (!en || $stable(dac_q))); // R5

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        wcnt_q < WC_W'(WAIT_SLOTS)); // R7

    AST_WAIT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> busy); // R9
endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper
    import vref_pkg::*;
#(
    parameter int unsigned VID_W = 8,
    parameter int unsigned CYC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [VID_W-1:0] vid_in,
    input  logic [CYC_W-1:0] cyc_len,
    output logic [VID_W-1:0] dac_code,
    output logic             busy
);
    logic [VID_W-1:0] vid_s;
    logic             strobe;

    vref_sync #(.W(VID_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (vid_in),
        .d_sync  (vid_s)
    );

    vref_slot_timer #(.CYC_W(CYC_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .cyc_len (cyc_len),
        .strobe  (strobe)
    );

    vref_stepper #(.VID_W(VID_W)) u_step (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .strobe   (strobe),
        .vid_s    (vid_s),
        .dac_code (dac_code),
        .busy     (busy)
    );

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(en)) |-> !busy); // R1
endmodule

// File: tb/vid_ref_stepper_tb.sv
module vid_ref_stepper_tb;
    localparam int VID_W = 8;
    localparam int CYC_W = 10;

    typedef struct {
        logic [VID_W-1:0] code;
        int               kind;   // 0: first step (latency), 1: chained (gap), 2: no timing check
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [VID_W-1:0] vid_in = '0;
    logic [CYC_W-1:0] cyc_len = CYC_W'(12);
    logic [VID_W-1:0] dac_code;
    logic             busy;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int t_drive = 0;
    int t_last  = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    vid_ref_stepper #(.VID_W(VID_W), .CYC_W(CYC_W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .vid_in   (vid_in),
        .cyc_len  (cyc_len),
        .dac_code (dac_code),
        .busy     (busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int code, input int kind);
        exp_t e;
        e.code = VID_W'(code);
        e.kind = kind;
        exp_q.push_back(e);
    endtask

    // Monitor: pops an expected item on every enabled change of dac_code
    logic [VID_W-1:0] prev_dac = '0;
    logic             prev_en  = 1'b0;
    always @(negedge clk) begin
        if (!rst && en && prev_en && dac_code != prev_dac) begin
            int half;
            half = int'(cyc_len) / 2;
            if (exp_q.size() == 0) begin
                check("R5 unexpected step", int'(dac_code), int'(prev_dac));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R4 step value", int'(dac_code), int'(e.code));
                if (e.kind == 0) begin
                    int lat;
                    lat = cyc - t_drive;
                    check("R3 first step not early", int'(lat >= half), 1);
                    check("R3 first step latency bound", int'(lat <= half + half / 3 + 3), 1);
                end else if (e.kind == 1) begin
                    check("R7 step gap", cyc - t_last, half);
                end
            end
            t_last = cyc;
        end
        prev_dac <= dac_code;
        prev_en  <= en && !rst;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset loads code directly
        vid_in = 8'd40;
        cyc_len = CYC_W'(12);
        tick(5);
        @(negedge clk);
        check("R1 reset dac", int'(dac_code), 40);
        check("R1 reset busy", int'(busy), 0);
        rst = 1'b0;
        tick(1);
        en = 1'b1;
        tick(4);
        @(negedge clk);
        check("R1 enable keeps dac", int'(dac_code), 40);

        // R3/R4: single up step
        @(posedge clk); #1;
        push(41, 0);
        vid_in = 8'd41;
        t_drive = cyc;
        tick(30);
        @(negedge clk);
        check("R4 single step dac", int'(dac_code), 41);
        check("R9 settled busy", int'(busy), 0);

        // R7: multi-step up, cycle 12
        push(42, 0); push(43, 1); push(44, 1);
        vid_in = 8'd44;
        t_drive = cyc;
        tick(60);
        @(negedge clk);
        check("R7 multi up reached", int'(dac_code), 44);

        // change cycle length while disabled
        en = 1'b0;
        cyc_len = CYC_W'(30);
        tick(2);
        en = 1'b1;
        tick(2);

        // R2/R7: multi-step down, cycle 30 (gap 15)
        push(43, 0); push(42, 1); push(41, 1);
        vid_in = 8'd41;
        t_drive = cyc;
        tick(8);
        @(negedge clk);
        check("R9 busy during wait", int'(busy), 1);
        tick(80);
        @(negedge clk);
        check("R2 multi down reached", int'(dac_code), 41);
        check("R9 busy clear", int'(busy), 0);

        // R5: code changes and returns within one wait: no step
        @(posedge clk); #1;
        vid_in = 8'd42;
        tick(8);
        vid_in = 8'd41;
        tick(60);
        @(negedge clk);
        check("R5 abandoned dac", int'(dac_code), 41);
        check("R5 abandoned busy", int'(busy), 0);

        // R6: difference changes mid-wait, then requalify toward new target
        @(posedge clk); #1;
        vid_in = 8'd42;
        tick(8);
        push(42, 2); push(43, 1);
        vid_in = 8'd43;
        tick(90);
        @(negedge clk);
        check("R6 requalified dac", int'(dac_code), 43);
        check("R6 settled busy", int'(busy), 0);

        // R1/R8: disabled tracking through two-flop synchronizer
        en = 1'b0;
        tick(3);
        @(posedge clk); #1;
        vid_in = 8'd60;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R8 not before third edge", int'(dac_code), 43);
        @(negedge clk);
        check("R8 third edge load", int'(dac_code), 60);
        check("R1 disabled busy", int'(busy), 0);
        en = 1'b1;
        tick(20);
        @(negedge clk);
        check("R1 enable rise no step", int'(dac_code), 60);

        check("R4 all steps seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule